// File: doc/BRIEF.md
# Fractional Baud and Frame Generator

This block derives the serial bit timing and the character format for an asynchronous serial port. It runs from one fixed reference clock (24 MHz nominal). Three configuration registers are written over a single shared data bus: a line setting, an integer divisor and a 3-bit fractional trim. Each bit is split into 16 oversample slots. The block pulses once at the end of every slot and once at the end of every bit. It also presents the character format in decoded form: data bit count, stop bit count, parity mode and an infrared-mode flag. It reports the length of one character both in bits and in reference clocks, so that neighbouring logic can time gaps and idle periods.

A bit lasts 16 × (divisor + 1) + trim reference clocks. The trim adds one clock to each of the first *trim* slots of every bit. The block keeps the three written values as stored copies. A write takes effect only when the stored divisor that results from it is non-zero. Until then, the timing and format in force stay as they were. Any register write restarts the slot and bit counters from the start of a fresh bit.

Top module: `ubaud_frame_gen`

## Requirements
- R1: After reset the format in force is 5 data bits, 1 stop bit, no parity and infrared off, with a word length of 7 bits. The divisor and trim in force are both zero, so a bit lasts 16 reference clocks.
- R2: With divisor D and trim F in force, consecutive bit pulses are exactly 16 × (D + 1) + F reference clocks apart.
- R3: Within each bit, the first F slots last D + 2 clocks and the remaining slots last D + 1 clocks. A slot pulse marks the last clock of each slot.
- R4: A write that leaves the stored divisor at zero changes neither the timing nor the format in force. The stored line setting and trim are kept, and they take effect together at the next write that leaves a non-zero stored divisor.
- R5: The data bit count equals line setting bits [1:0] plus 5, giving 5 to 8.
- R6: Line setting bit 2 set gives 2 stop bits. Clear gives 1.
- R7: The parity output is coded 0 = none, 1 = odd, 2 = even. Line setting bit 5 clear gives none, whatever bits 4 and 3 hold. Bit 5 set gives odd when bit 3 is clear and even when bit 3 is set. Bit 4 is ignored.
- R8: The infrared-mode output follows line setting bit 6.
- R9: The word length in bits equals data bits + stop bits + 1. The word length in clocks equals that number times the bit period of R2.
- R10: A write to any of the three registers restarts the divider. The first bit pulse after the write appears in the cycle that follows exactly one bit period of clock edges, counting the edge that takes the write.
- R11: Every bit pulse coincides with the 16th slot pulse since the previous bit pulse or restart.
- R12: The write strobes select the target register: 0 line setting from wr_data[6:0], divisor from the whole of wr_data, trim from wr_data[2:0]. Strobes that arrive together are all taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lcr_wr | input | 1 | Write strobe for the line setting |
| div_wr | input | 1 | Write strobe for the integer divisor |
| frac_wr | input | 1 | Write strobe for the fractional trim |
| wr_data | input | DIV_W | Shared write data |
| os_tick | output | 1 | Pulse on the last clock of each oversample slot |
| bit_tick | output | 1 | Pulse on the last clock of each bit |
| data_bits | output | 4 | Data bits per character (5 to 8) |
| stop_bits | output | 2 | Stop bits per character (1 or 2) |
| parity_mode | output | 2 | 0 none, 1 odd, 2 even |
| ir_mode | output | 1 | Infrared mode selected |
| word_bits | output | 4 | Bits per character including start and stop |
| word_clks | output | DIV_W+9 | Reference clocks per character |

## Verification
The bench builds the block with its default 16-bit divisor field. It uses divisors from 0 to 5 only, so every bit lasts at most about a hundred clocks. This keeps every trim value from 0 to 7 and every line-setting encoding within reach, with each slot length checked one by one. The upper divisor bits and the widest word-time products are left outside that range. Deferred writes while the stored divisor is zero are covered both straight after reset and after a running configuration.

// File: rtl/ubaud_pkg.sv
package ubaud_pkg;

    localparam int OS_SLOTS = 16;
    localparam int SLOT_W   = $clog2(OS_SLOTS);
    localparam int LINE_W   = 7;
    localparam int TRIM_W   = 3;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2
    } parity_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic [1:0] stop_bits;
        parity_e    parity;
        logic       ir;
    } frame_t;

    function automatic frame_t decode_line(input logic [LINE_W-1:0] ls);
        frame_t f;
        f.data_bits = 4'(ls[1:0]) + 4'd5;
        f.stop_bits = ls[2] ? 2'd2 : 2'd1;
        if (!ls[5])
            f.parity = PAR_NONE;
        else if (ls[3])
            f.parity = PAR_EVEN;
        else
            f.parity = PAR_ODD;
        f.ir = ls[6];
        return f;
    endfunction

endpackage

// File: rtl/ubaud_frame_decode.sv
module ubaud_frame_decode
    import ubaud_pkg::*;
(
    input  logic [LINE_W-1:0] line_set,
    output frame_t            frame,
    output logic [3:0]        word_bits
);
    always_comb begin
        frame     = decode_line(line_set);
        word_bits = frame.data_bits + {2'b00, frame.stop_bits} + 4'd1;
    end
endmodule

// File: rtl/ubaud_slot_divider.sv
module ubaud_slot_divider
    import ubaud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [TRIM_W-1:0] trim,
    output logic              os_tick,
    output logic              bit_tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic              long_slot;
    logic [CNT_W-1:0]  last_cnt;
    logic              slot_end;

    always_comb begin
        long_slot = slot_q < SLOT_W'(trim);
        last_cnt  = {1'b0, divisor} + CNT_W'(long_slot);
        slot_end  = (cnt_q == last_cnt);
        os_tick   = slot_end;
        bit_tick  = slot_end && (slot_q == SLOT_W'(OS_SLOTS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (slot_end) begin
            cnt_q  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ubaud_frame_gen.sv
module ubaud_frame_gen
    import ubaud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lcr_wr,
    input  logic             div_wr,
    input  logic             frac_wr,
    input  logic [DIV_W-1:0] wr_data,
    output logic             os_tick,
    output logic             bit_tick,
    output logic [3:0]       data_bits,
    output logic [1:0]       stop_bits,
    output logic [1:0]       parity_mode,
    output logic             ir_mode,
    output logic [3:0]       word_bits,
    output logic [DIV_W+8:0] word_clks
);
    localparam int PER_W  = DIV_W + 5;
    localparam int WCLK_W = DIV_W + 9;

    logic [LINE_W-1:0] line_q, eff_line, nxt_line;
    logic [DIV_W-1:0]  div_q, eff_div, nxt_div;
    logic [TRIM_W-1:0] trim_q, eff_trim, nxt_trim;
    logic              any_wr;
    frame_t            frame;
    logic [PER_W-1:0]  bit_period;

    always_comb begin
        nxt_line = lcr_wr  ? wr_data[LINE_W-1:0] : line_q;
        nxt_div  = div_wr  ? wr_data             : div_q;
        nxt_trim = frac_wr ? wr_data[TRIM_W-1:0] : trim_q;
        any_wr   = lcr_wr || div_wr || frac_wr;
    end

    // stored copies always follow writes; settings in force only with a non-zero divisor
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= '0;
            div_q    <= '0;
            trim_q   <= '0;
            eff_line <= '0;
            eff_div  <= '0;
            eff_trim <= '0;
        end else if (any_wr) begin
            line_q <= nxt_line;
            div_q  <= nxt_div;
            trim_q <= nxt_trim;
            if (nxt_div != '0) begin
                eff_line <= nxt_line;
                eff_div  <= nxt_div;
                eff_trim <= nxt_trim;
            end
        end
    end

    ubaud_frame_decode dec_i (
        .line_set  (eff_line),
        .frame     (frame),
        .word_bits (word_bits)
    );

    ubaud_slot_divider #(.DIV_W(DIV_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (any_wr),
        .divisor  (eff_div),
        .trim     (eff_trim),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    always_comb begin
        bit_period  = (PER_W'(eff_div) << SLOT_W) + PER_W'(OS_SLOTS) + PER_W'(eff_trim);
        word_clks   = WCLK_W'(word_bits) * WCLK_W'(bit_period);
        data_bits   = frame.data_bits;
        stop_bits   = frame.stop_bits;
        parity_mode = frame.parity;
        ir_mode     = frame.ir;
    end
endmodule

// File: rtl/ubaud_frame_gen_chk.sv
module ubaud_frame_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lcr_wr,
    input logic             div_wr,
    input logic             frac_wr,
    input logic [DIV_W-1:0] wr_data,
    input logic             os_tick,
    input logic             bit_tick,
    input logic [3:0]       data_bits,
    input logic [1:0]       stop_bits,
    input logic [1:0]       parity_mode,
    input logic             ir_mode,
    input logic [3:0]       word_bits,
    input logic [DIV_W+8:0] word_clks,
    input logic [DIV_W-1:0] eff_div
);
    logic             wr_seen;
    logic [DIV_W:0]   gap_q;
    logic [4:0]       os_cnt_q;

    assign wr_seen = lcr_wr || div_wr || frac_wr;

    always_ff @(posedge clk) begin
        if (rst || wr_seen || os_tick) gap_q <= '0;
        else                           gap_q <= gap_q + 1'b1;
        if (rst || wr_seen || bit_tick) os_cnt_q <= '0;
        else if (os_tick)               os_cnt_q <= os_cnt_q + 1'b1;
    end

    // R3
    slot_len_chk: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> (gap_q >= {1'b0, eff_div} && gap_q <= {1'b0, eff_div} + 1'b1));

    // R11
    bit_on_slot_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (os_tick && os_cnt_q == 5'd15));

    // R10
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_seen |=> !bit_tick);

    // R4
    zero_div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (div_wr && wr_data == '0 && !lcr_wr && !frac_wr) |=>
        ($stable(data_bits) && $stable(stop_bits) && $stable(parity_mode)
         && $stable(ir_mode) && $stable(word_clks)));

    // R5
    data_range_chk: assert property (@(posedge clk) disable iff (rst)
        data_bits >= 4'd5 && data_bits <= 4'd8);

    // R7
    parity_code_chk: assert property (@(posedge clk) disable iff (rst)
        parity_mode != 2'd3);

    // R9
    word_len_chk: assert property (@(posedge clk) disable iff (rst)
        word_bits == data_bits + {2'b00, stop_bits} + 4'd1);
endmodule

bind ubaud_frame_gen ubaud_frame_gen_chk #(.DIV_W(DIV_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .lcr_wr      (lcr_wr),
    .div_wr      (div_wr),
    .frac_wr     (frac_wr),
    .wr_data     (wr_data),
    .os_tick     (os_tick),
    .bit_tick    (bit_tick),
    .data_bits   (data_bits),
    .stop_bits   (stop_bits),
    .parity_mode (parity_mode),
    .ir_mode     (ir_mode),
    .word_bits   (word_bits),
    .word_clks   (word_clks),
    .eff_div     (eff_div)
);

// File: tb/ubaud_frame_gen_tb.sv
module ubaud_frame_gen_tb_top;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lcr_wr = 1'b0, div_wr = 1'b0, frac_wr = 1'b0;
    logic [DIV_W-1:0] wr_data = '0;
    logic             os_tick, bit_tick, ir_mode;
    logic [3:0]       data_bits, word_bits;
    logic [1:0]       stop_bits, parity_mode;
    logic [DIV_W+8:0] word_clks;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ubaud_frame_gen #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .lcr_wr(lcr_wr), .div_wr(div_wr), .frac_wr(frac_wr),
        .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick),
        .data_bits(data_bits), .stop_bits(stop_bits), .parity_mode(parity_mode),
        .ir_mode(ir_mode), .word_bits(word_bits), .word_clks(word_clks)
    );

    typedef struct packed {
        logic [6:0]  ls;
        logic [15:0] dv;
        logic [2:0]  tr;
        logic [3:0]  db;
        logic [1:0]  sb;
        logic [1:0]  par;
        logic        ir;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{7'h03, 16'd1, 3'd0, 4'd8, 2'd1, 2'd0, 1'b0},
        '{7'h24, 16'd2, 3'd3, 4'd5, 2'd2, 2'd1, 1'b0},
        '{7'h2E, 16'd3, 3'd7, 4'd7, 2'd2, 2'd2, 1'b0},
        '{7'h41, 16'd1, 3'd5, 4'd6, 2'd1, 2'd0, 1'b1},
        '{7'h1B, 16'd4, 3'd1, 4'd8, 2'd1, 2'd0, 1'b0},
        '{7'h3A, 16'd2, 3'd0, 4'd7, 2'd1, 2'd2, 1'b0},
        '{7'h30, 16'd5, 3'd2, 4'd5, 2'd1, 2'd1, 1'b0},
        '{7'h67, 16'd1, 3'd1, 4'd8, 2'd2, 2'd1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 line setting, 1 divisor, 2 trim
    task automatic wr(input int kind, input int d);
        @(negedge clk);
        wr_data = DIV_W'(d);
        lcr_wr  = (kind == 0);
        div_wr  = (kind == 1);
        frac_wr = (kind == 2);
        @(negedge clk);
        lcr_wr = 1'b0; div_wr = 1'b0; frac_wr = 1'b0;
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 4000 && !bit_tick; i++) @(negedge clk);
    endtask

    // called right after wr(): counts edges from the write edge to the first bit pulse
    task automatic first_tick(input string req, input int per);
        int n = 1;
        while (!bit_tick && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(req, n, per);
    endtask

    // called while bit_tick is visible; measures the following bit
    task automatic measure_bit(input int dv, input int tr);
        int n = 0, g = 0, slot = 0;
        do begin
            @(negedge clk);
            n++; g++;
            if (os_tick) begin
                chk("R3 slot length", g, dv + 1 + ((slot < tr) ? 1 : 0));
                g = 0;
                slot++;
            end
        end while (!bit_tick && n < 4000);
        chk("R2 bit period", n, 16 * (dv + 1) + tr);
        chk("R11 slots per bit", slot, 16);
    endtask

    task automatic check_frame(input string tag, input int db, input int sb,
                               input int par, input int ir, input int per);
        chk({tag, " R5 data bits"}, int'(data_bits), db);
        chk({tag, " R6 stop bits"}, int'(stop_bits), sb);
        chk({tag, " R7 parity"}, int'(parity_mode), par);
        chk({tag, " R8 infrared"}, int'(ir_mode), ir);
        chk({tag, " R9 word bits"}, int'(word_bits), db + sb + 1);
        chk({tag, " R9 word clocks"}, int'(word_clks), (db + sb + 1) * per);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_frame("R1", 5, 1, 0, 0, 16);
        wait_tick();
        measure_bit(0, 0);

        // R4: writes with stored divisor zero are deferred
        wr(0, 7'h67);
        check_frame("R4 line deferred", 5, 1, 0, 0, 16);
        wr(2, 5);
        wait_tick();
        measure_bit(0, 0);

        // table walk: R2 R3 R5..R10 R12
        foreach (VECS[i]) begin
            int per;
            per = 16 * (int'(VECS[i].dv) + 1) + int'(VECS[i].tr);
            wr(1, int'(VECS[i].dv));
            wr(2, int'(VECS[i].tr));
            wr(0, int'(VECS[i].ls));
            first_tick("R10 restart latency", per);
            check_frame("R12 vector", int'(VECS[i].db), int'(VECS[i].sb),
                        int'(VECS[i].par), int'(VECS[i].ir), per);
            measure_bit(int'(VECS[i].dv), int'(VECS[i].tr));
        end

        // R4: zero divisor after running configuration keeps the last one (8,2,odd,ir, period 33)
        wr(1, 0);
        check_frame("R4 zero divisor", 8, 2, 1, 1, 33);
        wait_tick();
        measure_bit(1, 1);
        wr(0, 0);
        check_frame("R4 line held", 8, 2, 1, 1, 33);
        // non-zero divisor applies stored line 0 and stored trim 1
        wr(1, 2);
        first_tick("R4 deferred apply", 49);
        check_frame("R4 applied", 5, 1, 0, 0, 49);
        measure_bit(2, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule